// File: doc/BRIEF.md
# Sampling Converter Serial Port Model

This block is a synthesizable stand-in for the digital side of a serial sampling converter. It is meant to be instantiated next to a host controller under verification. It has no analog front end. The value that would have been converted is presented on a parallel test port, and the block captures it whenever a valid convert request arrives. The block then shifts out the value captured on the request before, MSB first, on a data output that has its own drive-enable, so the host sees exactly one frame of latency.

All inputs are sampled on a fast system clock. The serial clock and the convert line are treated as slow data signals whose edges are found by comparing successive samples. The same convert line also carries power commands. Several convert pulses with no serial-clock edge between them move the model into a light or a deep idle state. While idle the data output stays undriven and new samples are not captured. Any serial-clock edge brings the model back to normal operation.

Top module: `serconv_slave`

## Requirements
- R1: Each accepted convert captures `sample_in`, and the frame started by that convert carries the word captured by the previous accepted convert.
- R2: After an accepted convert, `sdo_en` stays 0 through the first LEAD_CLKS (default 2) serial-clock rises, and returns to 0 on rise LEAD_CLKS+SLOTS+1 (default 17) and on every rise after it until the next accepted convert.
- R3: On rises LEAD_CLKS+1 to LEAD_CLKS+SLOTS (default 3 to 16), `sdo_en` is 1 and `sdo_out` shows the frame word MSB first, one bit per rise. Both outputs update one system clock after the rise is sampled.
- R4: When DATA_W is less than SLOTS, the sample fills the top slots and the remaining SLOTS-DATA_W slots carry the constant FILL_BIT.
- R5: A convert pulse is accepted only after `conv_in` has been high for MIN_CONV_W consecutive system-clock samples. A shorter pulse captures nothing, starts no frame and does not count toward a power command.
- R6: A second accepted-width convert pulse with no serial-clock edge since the previous one puts `pwr_state` at 2'b01 (nap), stops any frame in progress, and holds `sdo_en` at 0. A third such pulse leaves the state at nap.
- R7: A fourth or later such pulse puts `pwr_state` at 2'b10 (sleep), with `sdo_en` held at 0.
- R8: Any serial-clock edge, rising or falling, returns `pwr_state` to 2'b00 (active). No frame is sent after waking until the next accepted convert.
- R9: Convert pulses that produce or occur in nap or sleep capture no sample. The first frame after waking carries the word captured before the power command.
- R10: After reset, `pwr_state` is 2'b00, `sdo_en` is 0, and the captured word is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all inputs |
| rst | input | 1 | Synchronous active-high reset |
| conv_in | input | 1 | Convert request and power command line |
| sck_in | input | 1 | Serial clock from the host |
| sample_in | input | DATA_W | Parallel value captured on an accepted convert |
| sdo_out | output | 1 | Serial data bit |
| sdo_en | output | 1 | Drive enable for the data pin; 0 means high impedance |
| pwr_state | output | 2 | 2'b00 active, 2'b01 nap, 2'b10 sleep |

## Verification
The bench builds two copies side by side from the same convert and serial-clock stimulus. One uses DATA_W=14 so that the sample fills all 14 slots. The other uses DATA_W=12 with FILL_BIT=1, so the two filler slots after the last data bit are visible as ones. Both use MIN_CONV_W=2, which makes a one-cycle convert pulse fall below the threshold and shows that it is discarded. The default nap and sleep pulse counts of 2 and 4 let a short burst of pulses walk through both idle states and the wake path.

// File: rtl/serconv_pkg.sv
package serconv_pkg;
  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'b00,
    PWR_NAP    = 2'b01,
    PWR_SLEEP  = 2'b10
  } pwr_e;
endpackage

// File: rtl/serconv_conv_qual.sv
// Accepts a convert pulse once it has been high for MIN_W samples.
module serconv_conv_qual #(
  parameter int MIN_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic conv_in,
  output logic conv_evt
);
  localparam int HW = $clog2(MIN_W + 1);
  localparam logic [HW-1:0] HI_MAX  = HW'(MIN_W);
  localparam logic [HW-1:0] HI_FIRE = HW'(MIN_W - 1);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)                  hi_cnt <= '0;
    else if (!conv_in)        hi_cnt <= '0;
    else if (hi_cnt != HI_MAX) hi_cnt <= hi_cnt + HW'(1);
  end

  assign conv_evt = conv_in && (hi_cnt == HI_FIRE);
endmodule

// File: rtl/serconv_sck_edge.sv
// Finds rising and any edges of the sampled serial clock.
module serconv_sck_edge (
  input  logic clk,
  input  logic rst,
  input  logic sck_in,
  output logic sck_rise,
  output logic sck_any
);
  logic sck_q;

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck_in;
  end

  assign sck_rise = sck_in && !sck_q;
  assign sck_any  = sck_in != sck_q;
endmodule

// File: rtl/serconv_pwr_ctl.sv
// Counts convert pulses between serial-clock edges and tracks power state.
module serconv_pwr_ctl
  import serconv_pkg::*;
#(
  parameter int NAP_N   = 2,
  parameter int SLEEP_N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic conv_evt,
  input  logic sck_any,
  output logic accept,
  output logic cmd,
  output pwr_e state
);
  localparam int PW = $clog2(SLEEP_N + 1);
  localparam logic [PW-1:0] NAP_V   = PW'(NAP_N);
  localparam logic [PW-1:0] SLEEP_V = PW'(SLEEP_N);

  logic [PW-1:0] pc;
  logic [PW-1:0] pc_inc;

  assign pc_inc = (pc == SLEEP_V) ? pc : pc + PW'(1);
  assign accept = conv_evt && (sck_any || (state == PWR_ACTIVE && pc_inc < NAP_V));
  assign cmd    = conv_evt && !accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      state <= PWR_ACTIVE;
    end else if (sck_any) begin
      pc    <= conv_evt ? PW'(1) : '0;
      state <= PWR_ACTIVE;
    end else if (conv_evt) begin
      pc <= pc_inc;
      if (pc_inc >= SLEEP_V)    state <= PWR_SLEEP;
      else if (pc_inc >= NAP_V) state <= PWR_NAP;
    end
  end
endmodule

// File: rtl/serconv_frame_tx.sv
// Serializes one frame word after a lead-in of idle serial-clock rises.
module serconv_frame_tx #(
  parameter int SLOTS = 14,
  parameter int LEAD  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic             sck_rise,
  input  logic [SLOTS-1:0] word,
  output logic             sdo,
  output logic             sdo_en
);
  localparam int CW = $clog2(LEAD + SLOTS + 2);
  localparam logic [CW-1:0] DONE  = CW'(LEAD + SLOTS + 1);
  localparam logic [CW-1:0] FIRST = CW'(LEAD + 1);
  localparam logic [CW-1:0] LAST  = CW'(LEAD + SLOTS);

  logic [CW-1:0]    cnt;
  logic [CW-1:0]    nxt;
  logic [SLOTS-1:0] sh;

  assign nxt = cnt + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= DONE;
      sh     <= '0;
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
    end else if (start) begin
      cnt    <= '0;
      sh     <= word;
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
    end else if (stop) begin
      cnt    <= DONE;
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
    end else if (sck_rise && cnt != DONE) begin
      cnt <= nxt;
      if (nxt >= FIRST && nxt <= LAST) begin
        sdo_en <= 1'b1;
        sdo    <= sh[SLOTS-1];
        sh     <= {sh[SLOTS-2:0], 1'b0};
      end else begin
        sdo_en <= 1'b0;
        sdo    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serconv_slave.sv
module serconv_slave
  import serconv_pkg::*;
#(
  parameter int DATA_W       = 14,
  parameter int SLOTS        = 14,
  parameter int LEAD_CLKS    = 2,
  parameter int MIN_CONV_W   = 2,
  parameter int NAP_PULSES   = 2,
  parameter int SLEEP_PULSES = 4,
  parameter bit FILL_BIT     = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_in,
  input  logic              sck_in,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdo_out,
  output logic              sdo_en,
  output logic [1:0]        pwr_state
);
  localparam int FILL_W = SLOTS - DATA_W;

  logic              conv_evt;
  logic              sck_rise;
  logic              sck_any;
  logic              accept;
  logic              cmd;
  pwr_e              state;
  logic [DATA_W-1:0] held;
  logic [SLOTS-1:0]  word;

  serconv_conv_qual #(.MIN_W(MIN_CONV_W)) u_qual (
    .clk(clk), .rst(rst), .conv_in(conv_in), .conv_evt(conv_evt)
  );

  serconv_sck_edge u_edge (
    .clk(clk), .rst(rst), .sck_in(sck_in), .sck_rise(sck_rise), .sck_any(sck_any)
  );

  serconv_pwr_ctl #(.NAP_N(NAP_PULSES), .SLEEP_N(SLEEP_PULSES)) u_pwr (
    .clk(clk), .rst(rst), .conv_evt(conv_evt), .sck_any(sck_any),
    .accept(accept), .cmd(cmd), .state(state)
  );

  // Previous capture feeds the frame; the new capture waits for the next one.
  always_ff @(posedge clk) begin
    if (rst)         held <= '0;
    else if (accept) held <= sample_in;
  end

  if (FILL_W > 0) begin : g_fill
    assign word = {held, {FILL_W{FILL_BIT}}};
  end else begin : g_nofill
    assign word = held;
  end

  serconv_frame_tx #(.SLOTS(SLOTS), .LEAD(LEAD_CLKS)) u_tx (
    .clk(clk), .rst(rst), .start(accept), .stop(cmd), .sck_rise(sck_rise),
    .word(word), .sdo(sdo_out), .sdo_en(sdo_en)
  );

  assign pwr_state = state;
endmodule

// File: rtl/serconv_slave_chk.sv
module serconv_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       conv_in,
  input logic       sck_in,
  input logic       sdo_en,
  input logic [1:0] pwr_state
);
  // R2/R3: the pin starts driving only after a sampled serial-clock rise
  assert_drive_after_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_en) |-> ($past(sck_in) && !$past(sck_in, 2)));

  // R6: no drive while idle
  assert_quiet_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (pwr_state != 2'b00) |-> !sdo_en);

  // R7: leaving active needs the convert line high
  assert_enter_on_convert_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(pwr_state) == 2'b00 && pwr_state != 2'b00) |-> $past(conv_in));

  // R8: waking needs a serial-clock edge
  assert_wake_on_edge_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(pwr_state) != 2'b00 && pwr_state == 2'b00) |-> ($past(sck_in) != $past(sck_in, 2)));

  // R10: only three state codes exist
  assert_legal_state_R10: assert property (@(posedge clk) disable iff (rst)
    pwr_state != 2'b11);
endmodule

bind serconv_slave serconv_slave_chk u_chk (
  .clk(clk), .rst(rst), .conv_in(conv_in), .sck_in(sck_in),
  .sdo_en(sdo_en), .pwr_state(pwr_state)
);

// File: tb/serconv_slave_tb.sv
module serconv_slave_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv = 1'b0;
  logic sck = 1'b0;
  logic [13:0] s14 = '0;
  logic [11:0] s12 = '0;
  logic d14, e14, d12, e12;
  logic [1:0] p14, p12;

  int checks = 0;
  int failures = 0;
  logic [13:0] held14 = '0, send14;
  logic [11:0] held12 = '0, send12;

  typedef struct {
    logic en14; logic d14; logic en12; logic d12; int req;
  } exp_t;
  exp_t q[$];
  event smp_ev;

  always #2.5 clk = ~clk;

  serconv_slave #(.DATA_W(14), .MIN_CONV_W(2)) u_dut (
    .clk(clk), .rst(rst), .conv_in(conv), .sck_in(sck), .sample_in(s14),
    .sdo_out(d14), .sdo_en(e14), .pwr_state(p14));

  serconv_slave #(.DATA_W(12), .MIN_CONV_W(2), .FILL_BIT(1'b1)) u_dut12 (
    .clk(clk), .rst(rst), .conv_in(conv), .sck_in(sck), .sample_in(s12),
    .sdo_out(d12), .sdo_en(e12), .pwr_state(p12));

  task automatic check(input int req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expectation per serial-clock pulse
  initial begin
    forever begin
      exp_t it;
      @(smp_ev);
      it = q.pop_front();
      check(it.req, "en14", int'(e14), int'(it.en14));
      if (it.en14) check(it.req, "bit14", int'(d14), int'(it.d14));
      check(it.req, "en12", int'(e12), int'(it.en12));
      if (it.en12) check(it.req, "bit12", int'(d12), int'(it.d12));
    end
  end

  task automatic convert(input logic [13:0] v14, input logic [11:0] v12, input int w, input bit latch);
    @(negedge clk);
    s14 = v14; s12 = v12; conv = 1'b1;
    for (int i = 0; i < w; i++) @(negedge clk);
    conv = 1'b0;
    if (latch) begin
      send14 = held14; held14 = v14;
      send12 = held12; held12 = v12;
    end
  endtask

  // driver: push expectations, then pulse the serial clock 18 times
  task automatic run_frame(input logic [13:0] w14, input logic [11:0] w12, input bit live, input int req);
    for (int k = 1; k <= 18; k++) begin
      exp_t it;
      it.req = req; it.en14 = 1'b0; it.d14 = 1'b0; it.en12 = 1'b0; it.d12 = 1'b0;
      if (live && k >= 3 && k <= 16) begin
        it.en14 = 1'b1; it.d14 = w14[16 - k];
        it.en12 = 1'b1;
        if (k <= 14) it.d12 = w12[14 - k];
        else begin it.d12 = 1'b1; it.req = 4; end // R4 filler slots
      end else if (live) it.req = 2;               // R2 idle slots
      q.push_back(it);
      @(negedge clk); sck = 1'b1;
      @(negedge clk); -> smp_ev; sck = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(10, "en after reset", int'(e14), 0);
    check(10, "pwr after reset", int'(p14), 0);
    check(10, "pwr12 after reset", int'(p12), 0);

    // R10 first frame carries the zero reset word; R1 one-frame latency
    convert(14'h3A5C, 12'hA5C, 2, 1'b1); run_frame(send14, send12, 1'b1, 10);
    convert(14'h2001, 12'h801, 2, 1'b1); run_frame(send14, send12, 1'b1, 1);
    convert(14'h1FFE, 12'h7FE, 2, 1'b1); run_frame(send14, send12, 1'b1, 3);

    // R5 short convert pulse ignored
    convert(14'h0F0F, 12'h0F0, 1, 1'b0);
    check(5, "pwr after short pulse", int'(p14), 0);
    run_frame('0, '0, 1'b0, 5);
    convert(14'h0333, 12'h333, 2, 1'b1); run_frame(send14, send12, 1'b1, 5);

    // R6 nap after two pulses, third stays nap
    convert(14'h1111, 12'h111, 2, 1'b1);
    convert(14'h2222, 12'h222, 2, 1'b0);
    check(6, "pwr nap", int'(p14), 1);
    check(6, "en in nap", int'(e14), 0);
    convert(14'h3333, 12'h333, 2, 1'b0);
    check(6, "pwr still nap", int'(p12), 1);
    // R8 wake, no frame until next convert
    run_frame('0, '0, 1'b0, 8);
    check(8, "pwr after wake", int'(p14), 0);
    // R9 nap pulses captured nothing
    convert(14'h0444, 12'h444, 2, 1'b1); run_frame(send14, send12, 1'b1, 9);

    // R7 sleep after four pulses, fifth stays sleep
    convert(14'h2468, 12'h468, 2, 1'b1);
    convert(14'h3001, 12'h001, 2, 1'b0);
    convert(14'h3002, 12'h002, 2, 1'b0);
    convert(14'h3003, 12'h003, 2, 1'b0);
    check(7, "pwr sleep", int'(p14), 2);
    check(7, "en in sleep", int'(e12), 0);
    convert(14'h3004, 12'h004, 2, 1'b0);
    check(7, "pwr still sleep", int'(p12), 2);
    run_frame('0, '0, 1'b0, 8);
    check(8, "pwr after sleep wake", int'(p14), 0);
    convert(14'h0001, 12'h001, 2, 1'b1); run_frame(send14, send12, 1'b1, 9);
    convert(14'h2AAA, 12'hAAA, 2, 1'b1); run_frame(send14, send12, 1'b1, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule